// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each received Ethernet frame, whether the frame is kept. The destination address arrives one byte per cycle on a valid/ready stream, first byte marked. The block tracks three address classes as the bytes go by. Broadcast means all 48 bits are ones. Physical match means the address equals the programmed station address. Multicast means the group bit is set and a 64-bit hash table has the bit set that the address's CRC selects.

The three class flags are registered one cycle after the sixth address byte, for the receive status word. When the frame-end strobe arrives with the frame length and error indication, a final decision is registered one cycle later. The decision applies the per-class enables, the policies for short frames and errored frames, and the promiscuous override. The stream never back-pressures: `da_ready` is held high. A byte transfers on any cycle with `da_valid` high. Bytes that arrive outside an address window are consumed and discarded.

Top module: `rx_addr_filter`

## Requirements
- R1: `da_ready` is always 1. A byte with `da_valid`=1 and `da_first`=1 starts a new address. Valid bytes seen before any `da_first`, or after frame end, change no output.
- R2: One cycle after the sixth address byte transfers, `cls_valid` pulses for one cycle and the flags take that address's classes. Bytes after the sixth leave the flags and the decision unchanged.
- R3: `bcast_hit` is 1 exactly when all 48 address bits are 1.
- R4: `phys_hit` is 1 when the address matches the station address. Address byte k (k=0 first on the wire) is compared with `sta_lo[8k+7:8k]` for k<4, and with `sta_hi[8(k-4)+7:8(k-4)]` for k=4,5.
- R5: `mcast_hit` is 1 when bit 0 of byte 0 is 1, the address is not broadcast, and table bit `idx` is set. The table is {`hash_w1`,`hash_w0`} (bit i of the 64-bit value). `idx` is bits 31:26 of a CRC register. The register starts at all ones and takes each byte LSB first. For each bit it shifts left, and XORs 0x04C11DB7 in when the old bit 31 differs from the input bit. There is no final inversion.
- R6: With `hash_swap`=1 the table is {bswap(`hash_w0`), bswap(`hash_w1`)}, where bswap reverses the four bytes of a word.
- R7: `dec_valid` pulses one cycle after `eof`, and `accept` holds the decision until the next `eof`. Without overrides a frame is accepted when a class it has is enabled: `ctrl[1]` physical, `ctrl[2]` multicast, `ctrl[3]` broadcast.
- R8: A frame with `frame_len` < 64 is rejected unless `ctrl[4]` is 1.
- R9: A frame with `frame_err`=1 is rejected unless `ctrl[5]` is 1.
- R10: `ctrl[0]`=1 accepts every frame, including one whose address is incomplete.
- R11: An `eof` in the same cycle as the sixth byte decides on the complete address. An `eof` before six bytes is rejected unless R10 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl | input | 6 | Acceptance enables (bit map in R7 to R10) |
| sta_lo | input | 32 | Station address bytes 0..3 |
| sta_hi | input | 16 | Station address bytes 4..5 |
| hash_w0 | input | 32 | Hash table word 0 |
| hash_w1 | input | 32 | Hash table word 1 |
| hash_swap | input | 1 | Byte-reversed hash word layout |
| da_valid | input | 1 | Address byte valid |
| da_ready | output | 1 | Always high |
| da_first | input | 1 | Marks first address byte |
| da_byte | input | 8 | Address byte |
| eof | input | 1 | Frame end strobe |
| frame_len | input | 16 | Frame length in bytes, sampled at eof |
| frame_err | input | 1 | Frame error, sampled at eof |
| cls_valid | output | 1 | Class flags updated |
| bcast_hit | output | 1 | Broadcast address received |
| phys_hit | output | 1 | Station address matched |
| mcast_hit | output | 1 | Multicast hash hit |
| dec_valid | output | 1 | Decision updated |
| accept | output | 1 | Keep the frame |

## Verification
Class evaluation and the frame decision can fall in the same cycle. This happens when `eof` arrives together with the sixth address byte. The decision must then use the byte still being absorbed, not the registered partial state. The bench provokes this with directed and random frames that end on the sixth byte, and also with frames that end earlier or later. A behavioural model built from whole-address arithmetic judges every output on every clock.

// File: rtl/af_pkg.sv
package af_pkg;
  localparam int CTL_W    = 6;
  localparam int CB_ALL   = 0;
  localparam int CB_PHYS  = 1;
  localparam int CB_MCAST = 2;
  localparam int CB_BCAST = 3;
  localparam int CB_RUNT  = 4;
  localparam int CB_ERR   = 5;
  localparam int CRC_W    = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;

  typedef struct packed {
    logic bcast;
    logic phys;
    logic mcast;
  } match_t;
endpackage

// File: rtl/af_crc_step.sv
module af_crc_step #(
  parameter int DW = 8
) (
  input  logic [af_pkg::CRC_W-1:0] crc_i,
  input  logic [DW-1:0]            data_i,
  output logic [af_pkg::CRC_W-1:0] crc_o
);
  always_comb begin
    logic [af_pkg::CRC_W-1:0] c;
    logic fb;
    c = crc_i;
    for (int j = 0; j < DW; j++) begin
      fb = c[af_pkg::CRC_W-1] ^ data_i[j];
      c  = {c[af_pkg::CRC_W-2:0], 1'b0};
      if (fb) c = c ^ af_pkg::CRC_POLY;
    end
    crc_o = c;
  end
endmodule

// File: rtl/af_hash_lookup.sv
module af_hash_lookup #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] w0,
  input  logic [WORD_W-1:0] w1,
  input  logic              swap,
  output logic              hit
);
  localparam int NB = WORD_W / 8;

  logic [WORD_W-1:0]   lo_sw, hi_sw;
  logic [2*WORD_W-1:0] table_v;

  for (genvar b = 0; b < NB; b++) begin : g_rev
    assign lo_sw[8*b +: 8] = w1[8*(NB-1-b) +: 8];
    assign hi_sw[8*b +: 8] = w0[8*(NB-1-b) +: 8];
  end

  assign table_v = swap ? {hi_sw, lo_sw} : {w1, w0};
  assign hit     = table_v[idx];
endmodule

// File: rtl/af_addr_track.sv
module af_addr_track #(
  parameter int ADDR_BYTES = 6,
  parameter int IDX_W      = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    da_valid,
  input  logic                    da_first,
  input  logic [7:0]              da_byte,
  input  logic                    eof,
  input  logic [8*ADDR_BYTES-1:0] station,
  output logic                    last_byte,
  output logic                    done_nx,
  output logic                    phys_nx,
  output logic                    bc_nx,
  output logic                    grp_nx,
  output logic [IDX_W-1:0]        hash_idx
);
  localparam int CW = $clog2(ADDR_BYTES + 1);
  localparam logic [CW-1:0] LAST_POS = CW'(ADDR_BYTES - 1);
  localparam logic [CW-1:0] FULL     = CW'(ADDR_BYTES);

  logic [CW-1:0]            cnt, pos, cnt_take;
  logic                     phys_r, bc_r, grp_r;
  logic [af_pkg::CRC_W-1:0] crc_r, crc_base, crc_step, crc_nx;
  logic [7:0]               sta_b [ADDR_BYTES];
  logic                     take;

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_sta
    assign sta_b[k] = station[8*k +: 8];
  end

  assign take     = da_valid && (da_first || (cnt != '0 && cnt < FULL));
  assign pos      = da_first ? '0 : cnt;
  assign crc_base = da_first ? '1 : crc_r;

  af_crc_step #(.DW(8)) u_crc (
    .crc_i (crc_base),
    .data_i(da_byte),
    .crc_o (crc_step)
  );

  always_comb begin
    phys_nx  = phys_r;
    bc_nx    = bc_r;
    grp_nx   = grp_r;
    crc_nx   = crc_r;
    cnt_take = cnt;
    if (take) begin
      phys_nx  = (da_first || phys_r) && (da_byte == sta_b[pos]);
      bc_nx    = (da_first || bc_r) && (&da_byte);
      grp_nx   = da_first ? da_byte[0] : grp_r;
      crc_nx   = crc_step;
      cnt_take = pos + 1'b1;
    end
  end

  assign last_byte = take && (pos == LAST_POS);
  assign done_nx   = (cnt_take == FULL);
  assign hash_idx  = crc_nx[af_pkg::CRC_W-1 -: IDX_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      phys_r <= 1'b0;
      bc_r   <= 1'b0;
      grp_r  <= 1'b0;
      crc_r  <= '1;
    end else begin
      cnt    <= eof ? '0 : cnt_take;
      phys_r <= phys_nx;
      bc_r   <= bc_nx;
      grp_r  <= grp_nx;
      crc_r  <= crc_nx;
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);
  // R1
  stray_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !da_first && cnt == '0) |=> (cnt == '0));
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter #(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 6,
  parameter int LEN_W      = 16,
  parameter int MIN_LEN    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [5:0]       ctrl,
  input  logic [31:0]      sta_lo,
  input  logic [15:0]      sta_hi,
  input  logic [31:0]      hash_w0,
  input  logic [31:0]      hash_w1,
  input  logic             hash_swap,
  input  logic             da_valid,
  output logic             da_ready,
  input  logic             da_first,
  input  logic [7:0]       da_byte,
  input  logic             eof,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             frame_err,
  output logic             cls_valid,
  output logic             bcast_hit,
  output logic             phys_hit,
  output logic             mcast_hit,
  output logic             dec_valid,
  output logic             accept
);
  import af_pkg::*;

  localparam logic [LEN_W-1:0] RUNT_LIM = LEN_W'(MIN_LEN);

  logic              last_byte, done_nx, phys_nx, bc_nx, grp_nx, hash_hit;
  logic [HASH_W-1:0] hash_idx;
  match_t            cls_nx;
  logic              addr_pass, is_runt, acc_nx;

  assign da_ready = 1'b1;

  af_addr_track #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(HASH_W)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .da_valid (da_valid),
    .da_first (da_first),
    .da_byte  (da_byte),
    .eof      (eof),
    .station  ({sta_hi, sta_lo}),
    .last_byte(last_byte),
    .done_nx  (done_nx),
    .phys_nx  (phys_nx),
    .bc_nx    (bc_nx),
    .grp_nx   (grp_nx),
    .hash_idx (hash_idx)
  );

  af_hash_lookup #(.WORD_W(32), .IDX_W(HASH_W)) u_hash (
    .idx (hash_idx),
    .w0  (hash_w0),
    .w1  (hash_w1),
    .swap(hash_swap),
    .hit (hash_hit)
  );

  always_comb begin
    cls_nx.bcast = bc_nx;
    cls_nx.phys  = phys_nx;
    cls_nx.mcast = grp_nx && !bc_nx && hash_hit;
    addr_pass = done_nx && ((ctrl[CB_BCAST] && cls_nx.bcast) ||
                            (ctrl[CB_PHYS]  && cls_nx.phys)  ||
                            (ctrl[CB_MCAST] && cls_nx.mcast));
    is_runt = frame_len < RUNT_LIM;
    acc_nx  = ctrl[CB_ALL] ||
              (addr_pass && (!is_runt || ctrl[CB_RUNT]) && (!frame_err || ctrl[CB_ERR]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cls_valid <= 1'b0;
      bcast_hit <= 1'b0;
      phys_hit  <= 1'b0;
      mcast_hit <= 1'b0;
      dec_valid <= 1'b0;
      accept    <= 1'b0;
    end else begin
      cls_valid <= last_byte;
      if (last_byte) begin
        bcast_hit <= cls_nx.bcast;
        phys_hit  <= cls_nx.phys;
        mcast_hit <= cls_nx.mcast;
      end
      dec_valid <= eof;
      if (eof) accept <= acc_nx;
    end
  end

  // R1
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) da_ready);
  // R3
  class_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bcast_hit && mcast_hit));
  // R7
  dec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(eof));
  // R10
  all_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && ctrl[CB_ALL]) |=> accept);
  // R8
  runt_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && !ctrl[CB_ALL] && !ctrl[CB_RUNT] && frame_len < RUNT_LIM) |=> !accept);
  // R9
  err_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof && !ctrl[CB_ALL] && !ctrl[CB_ERR] && frame_err) |=> !accept);
endmodule

// File: tb/sim_rx_addr_filter.sv
module sim_rx_addr_filter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [5:0]  ctrl = '0;
  logic [31:0] sta_lo = 32'h3C2B1A02;
  logic [15:0] sta_hi = 16'h5E4D;
  logic [31:0] hash_w0 = '0, hash_w1 = '0;
  logic        hash_swap = 0;
  logic        da_valid = 0, da_first = 0, eof = 0, frame_err = 0;
  logic [7:0]  da_byte = '0;
  logic [15:0] frame_len = '0;
  logic        da_ready, cls_valid, bcast_hit, phys_hit, mcast_hit, dec_valid, accept;

  int checks = 0, errors = 0;
  bit running = 0;

  always #10 clk = ~clk;

  rx_addr_filter u0 (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .sta_lo(sta_lo), .sta_hi(sta_hi),
    .hash_w0(hash_w0), .hash_w1(hash_w1), .hash_swap(hash_swap),
    .da_valid(da_valid), .da_ready(da_ready), .da_first(da_first), .da_byte(da_byte),
    .eof(eof), .frame_len(frame_len), .frame_err(frame_err),
    .cls_valid(cls_valid), .bcast_hit(bcast_hit), .phys_hit(phys_hit),
    .mcast_hit(mcast_hit), .dec_valid(dec_valid), .accept(accept)
  );

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb = c[31] ^ a[i];
      c = c << 1;
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c;
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [2:0] ref_class(input logic [47:0] a);
    logic [63:0] tbl;
    logic [31:0] c;
    logic bc, ph, mc;
    tbl = hash_swap ? {bswap(hash_w0), bswap(hash_w1)} : {hash_w1, hash_w0};
    c   = ref_crc(a);
    bc  = (a == 48'hFFFF_FFFF_FFFF);
    ph  = (a == {sta_hi, sta_lo});
    mc  = a[0] && !bc && tbl[c[31:26]];
    return {bc, ph, mc};
  endfunction

  function automatic logic ref_decide(input bit done, input logic [47:0] a);
    logic [2:0] k;
    logic pass;
    if (ctrl[0]) return 1'b1;
    if (!done) return 1'b0;
    k = ref_class(a);
    pass = (ctrl[3] && k[2]) || (ctrl[1] && k[1]) || (ctrl[2] && k[0]);
    return pass && (frame_len >= 64 || ctrl[4]) && (!frame_err || ctrl[5]);
  endfunction

  // behavioural reference, advanced on each rising edge
  int          m_cnt = 0;
  logic [47:0] m_a = '0;
  logic        e_cls = 0, e_bc = 0, e_ph = 0, e_mc = 0, e_dv = 0, e_acc = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; e_cls = 0; e_bc = 0; e_ph = 0; e_mc = 0; e_dv = 0; e_acc = 0;
    end else begin
      int pos;
      bit tk;
      tk = 0; pos = 0;
      if (da_valid && da_first) begin tk = 1; pos = 0; end
      else if (da_valid && m_cnt > 0 && m_cnt < 6) begin tk = 1; pos = m_cnt; end
      if (tk) begin m_a[8*pos +: 8] = da_byte; m_cnt = pos + 1; end
      e_cls = tk && (pos == 5);
      if (e_cls) {e_bc, e_ph, e_mc} = ref_class(m_a);
      e_dv = eof;
      if (eof) begin
        e_acc = ref_decide(m_cnt == 6, m_a);
        m_cnt = 0;
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      chk(da_ready,  1'b1,  "R1 da_ready");
      chk(cls_valid, e_cls, "R2 cls_valid");
      chk(bcast_hit, e_bc,  "R3 bcast_hit");
      chk(phys_hit,  e_ph,  "R4 phys_hit");
      chk(mcast_hit, e_mc,  "R5/R6 mcast_hit");
      chk(dec_valid, e_dv,  "R7 dec_valid");
      chk(accept,    e_acc, "R7 accept");
    end
  end

  task automatic send(input logic [47:0] a, input int nb, input int extra, input int len,
                      input bit err, input bit eof_last, input int stray);
    int total;
    for (int s = 0; s < stray; s++) begin
      da_valid = 1; da_first = 0; da_byte = 8'hFF;
      @(negedge clk);
    end
    da_valid = 0;
    total = nb + extra;
    for (int i = 0; i < total; i++) begin
      da_valid = 1; da_first = (i == 0);
      da_byte = (i < nb) ? a[8*i +: 8] : 8'($urandom);
      eof = eof_last && (i == total - 1);
      frame_len = 16'(len); frame_err = err;
      @(negedge clk);
      da_valid = 0; da_first = 0; eof = 0;
      if ($urandom % 4 == 0) @(negedge clk);
    end
    if (!eof_last) begin
      eof = 1; frame_len = 16'(len); frame_err = err;
      @(negedge clk);
      eof = 0;
    end
    @(negedge clk);
  endtask

  localparam logic [47:0] STA = 48'h5E4D_3C2B_1A02;
  localparam logic [47:0] BC  = 48'hFFFF_FFFF_FFFF;
  localparam logic [47:0] UNI = 48'h5E4D_3C2B_1A04;
  localparam logic [47:0] MC  = 48'h0100_005E_0001;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7 actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cls_valid | dec_valid | accept | bcast_hit | phys_hit | mcast_hit, 1'b0, "R2/R7 reset");
    rst_n = 1;
    running = 1;
    @(negedge clk);

    ctrl = 6'b001110;
    send(STA, 6, 4, 100, 0, 0, 0);  chk(accept, 1, "R4 station accepted");
    chk(phys_hit, 1, "R4 phys flag");
    send(UNI, 6, 0, 100, 0, 0, 0);  chk(accept, 0, "R7 other unicast rejected");
    send(BC, 6, 2, 100, 0, 0, 0);   chk(accept, 1, "R3 broadcast accepted");
    chk(bcast_hit, 1, "R3 bcast flag");
    ctrl = 6'b000110;
    send(BC, 6, 2, 100, 0, 0, 0);   chk(accept, 0, "R7 broadcast disabled");
    ctrl = 6'b001110;
    hash_w0 = '0; hash_w1 = '0;
    send(MC, 6, 0, 100, 0, 0, 0);   chk(accept, 0, "R5 empty table rejects");
    hash_w0 = '1; hash_w1 = '1;
    send(MC, 6, 0, 100, 0, 0, 0);   chk(accept, 1, "R5 full table accepts");
    chk(mcast_hit, 1, "R5 mcast flag");
    begin
      logic [31:0] c;
      logic [63:0] one;
      c = ref_crc(MC);
      one = 64'd1 << c[31:26];
      hash_swap = 0; hash_w0 = one[31:0]; hash_w1 = one[63:32];
      send(MC, 6, 0, 100, 0, 0, 0); chk(accept, 1, "R5 single hash bit");
      hash_swap = 1; hash_w0 = bswap(one[63:32]); hash_w1 = bswap(one[31:0]);
      send(MC, 6, 0, 100, 0, 0, 0); chk(accept, 1, "R6 swapped hash bit");
      hash_swap = 0;
    end
    send(STA, 6, 0, 40, 0, 0, 0);   chk(accept, 0, "R8 runt rejected");
    ctrl = 6'b011110;
    send(STA, 6, 0, 40, 0, 0, 0);   chk(accept, 1, "R8 runt allowed");
    ctrl = 6'b001110;
    send(STA, 6, 0, 100, 1, 0, 0);  chk(accept, 0, "R9 error rejected");
    ctrl = 6'b101110;
    send(STA, 6, 0, 100, 1, 0, 0);  chk(accept, 1, "R9 error allowed");
    ctrl = 6'b000001;
    send(UNI, 6, 0, 10, 1, 0, 0);   chk(accept, 1, "R10 accept-all");
    send(UNI, 3, 0, 10, 0, 1, 0);   chk(accept, 1, "R10 short address");
    ctrl = 6'b001110;
    send(STA, 6, 0, 100, 0, 1, 0);  chk(accept, 1, "R11 eof with sixth byte");
    send(STA, 3, 0, 100, 0, 1, 0);  chk(accept, 0, "R11 eof before sixth byte");
    send(STA, 6, 12, 100, 0, 1, 3); chk(accept, 1, "R1 stray and trailing bytes");
    chk(phys_hit, 1, "R2 flags kept after trailing bytes");

    for (int n = 0; n < 300; n++) begin
      logic [47:0] a;
      int sel;
      sel = $urandom % 4;
      a = (sel == 0) ? STA : (sel == 1) ? BC :
          (sel == 2) ? {$urandom, 16'($urandom)} | 48'h1 : {$urandom, 16'($urandom)};
      ctrl = 6'($urandom);
      if ($urandom % 3 != 0) ctrl[0] = 0;
      hash_w0 = $urandom; hash_w1 = $urandom; hash_swap = 1'($urandom);
      send(a, ($urandom % 4 == 0) ? 1 + $urandom % 6 : 6, $urandom % 4,
           20 + $urandom % 100, ($urandom % 4 == 0), 1'($urandom), $urandom % 2);
    end

    running = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule